// File: doc/BRIEF.md
# Video/data switch alignment stage

This output stage sits at the end of a display pipeline, in the line-locked display clock domain (nominally 12 MHz). It receives the internally generated RGB pixel values and a switch signal that tells the downstream mixer, pixel by pixel, whether to show the generated RGB or the incoming video. Both are registered and driven to the pins.

Two adjustments are applied to the switch signal only.

- **Polarity.** A polarity bit sets which output level means "show RGB".
- **Alignment.** A 3-bit alignment code moves the switch one clock earlier than the RGB data, one clock later, or leaves it coincident. External buffers on the switch path can add delay that differs from the RGB path, and the alignment code lets that difference be cancelled.

RGB latency is the same in every alignment mode. Both configuration inputs are sampled every clock, so a new setting shows at the outputs after the next edge.

Top module: `vds_align_stage`

## Requirements
- R1: While reset is asserted, and right after it, `rgb_o` is all zeros and `sw_o` is 0. With polarity 0, an `sw_o` of 0 means video display.
- R2: `rgb_o` equals `rgb_i` delayed by exactly two clocks, whatever the alignment code and polarity.
- R3: With `align_sel_i` = 3'b000 (coincident), the logical switch value at `sw_o` is `sw_i` delayed by two clocks, the same as the RGB delay.
- R4: With `align_sel_i` = 3'b001 (early), the logical switch value at `sw_o` is `sw_i` delayed by one clock, one clock ahead of the matching RGB.
- R5: With `align_sel_i` = 3'b010 (late), the logical switch value at `sw_o` is `sw_i` delayed by three clocks, one clock behind the matching RGB.
- R6: The codes 3'b011 to 3'b111 behave exactly as 3'b000.
- R7: `sw_i` = 1 requests RGB display. With `sw_pol_i` = 0, `sw_o` = 1 selects RGB and 0 selects video. With `sw_pol_i` = 1, the output level is inverted: 0 selects RGB and 1 selects video.
- R8: A change of `align_sel_i` or `sw_pol_i` sampled at a clock edge shows at `sw_o` right after that edge. The switch delay line keeps running in every mode, so history older than the change is still used after a mode switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-locked display clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| align_sel_i | input | 3 | Switch alignment code (000 coincident, 001 early, 010 late, other codes coincident) |
| sw_pol_i | input | 1 | Switch output polarity (0: high selects RGB, 1: low selects RGB) |
| rgb_i | input | N_CH*CH_W | Generated pixel colour, channel 0 in the low bits |
| sw_i | input | 1 | Logical switch request, 1 selects RGB display |
| rgb_o | output | N_CH*CH_W | Registered pixel colour to the pins |
| sw_o | output | 1 | Aligned switch signal with polarity applied |

## Verification
A pseudo-random switch and colour stream runs through every alignment code under both polarities. Each mode delays the switch by a different amount, so a wrong tap shows up as a mismatch against a bench history of past inputs, while RGB is compared against its fixed two-clock history at the same time. The undefined codes 011 to 111 are run separately to show that they fall back to coincident and do not alias early or late. Directed sequences then do three things:
- toggle the polarity every clock with a constant switch, to separate a registered polarity from a combinational or stale one;
- swap between early and late every clock, to show that the delay line keeps running through a mode change;
- apply an asynchronous reset mid-stream, to confirm the video-display reset level.

// File: rtl/vds_align_pkg.sv
package vds_align_pkg;

  typedef enum logic [1:0] {
    ALIGN_COINC = 2'd0,
    ALIGN_EARLY = 2'd1,
    ALIGN_LATE  = 2'd2
  } align_e;

  // undefined codes fall back to coincident
  function automatic align_e decode_align(input logic [2:0] code);
    unique case (code)
      3'b001:  return ALIGN_EARLY;
      3'b010:  return ALIGN_LATE;
      default: return ALIGN_COINC;
    endcase
  endfunction

endpackage

// File: rtl/vds_pix_pipe.sv
module vds_pix_pipe #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [DEPTH:1][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[1] <= d_i;
      for (int i = 2; i <= DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH];

endmodule

// File: rtl/vds_sw_delay.sv
module vds_sw_delay #(
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_i,
  output logic [DEPTH:0] tap_o
);

  logic [DEPTH:1] dl_q;

  // runs in every mode so a mode switch sees valid history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dl_q <= '0;
    end else begin
      dl_q[1] <= sw_i;
      for (int i = 2; i <= DEPTH; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  assign tap_o = {dl_q, sw_i};

endmodule

// File: rtl/vds_sw_out.sv
module vds_sw_out
  import vds_align_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DEPTH:0] tap_i,
  input  logic [2:0]     align_sel_i,
  input  logic           sw_pol_i,
  output logic           sw_o
);

  // output reg adds one stage: tap k gives total latency k+1
  localparam int unsigned TapEarly = DEPTH - 2;
  localparam int unsigned TapCoinc = DEPTH - 1;
  localparam int unsigned TapLate  = DEPTH;

  align_e mode;
  logic   sel_d;
  logic   sw_q;
  logic   pol_q;

  assign mode = decode_align(align_sel_i);

  always_comb begin
    unique case (mode)
      ALIGN_EARLY: sel_d = tap_i[TapEarly];
      ALIGN_LATE:  sel_d = tap_i[TapLate];
      default:     sel_d = tap_i[TapCoinc];
    endcase
  end

  // polarity registered alongside so reset lands on video condition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      sw_q  <= sel_d;
      pol_q <= sw_pol_i;
    end
  end

  assign sw_o = sw_q ^ pol_q;

endmodule

// File: rtl/vds_align_stage.sv
module vds_align_stage #(
  parameter int unsigned N_CH       = 3,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned PIPE_DEPTH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2:0]           align_sel_i,
  input  logic                 sw_pol_i,
  input  logic [N_CH*CH_W-1:0] rgb_i,
  input  logic                 sw_i,
  output logic [N_CH*CH_W-1:0] rgb_o,
  output logic                 sw_o
);

  localparam int unsigned PixW = N_CH * CH_W;

  logic [PIPE_DEPTH:0] sw_tap;

  if (PIPE_DEPTH < 2) begin : g_bad_depth
    initial $error("PIPE_DEPTH must be at least 2");
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    vds_pix_pipe #(
      .W    (CH_W),
      .DEPTH(PIPE_DEPTH)
    ) u_pipe (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (rgb_i[ch*CH_W +: CH_W]),
      .q_o   (rgb_o[ch*CH_W +: CH_W])
    );
  end

  vds_sw_delay #(
    .DEPTH(PIPE_DEPTH)
  ) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sw_i  (sw_i),
    .tap_o (sw_tap)
  );

  vds_sw_out #(
    .DEPTH(PIPE_DEPTH)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tap_i      (sw_tap),
    .align_sel_i(align_sel_i),
    .sw_pol_i   (sw_pol_i),
    .sw_o       (sw_o)
  );

  if (PixW == 0) begin : g_bad_width
    initial $error("pixel width must be non-zero");
  end

endmodule

// File: rtl/vds_align_chk.sv
module vds_align_chk #(
  parameter int unsigned N_CH       = 3,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned PIPE_DEPTH = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2:0]           align_sel_i,
  input logic                 sw_pol_i,
  input logic [N_CH*CH_W-1:0] rgb_i,
  input logic                 sw_i,
  input logic [N_CH*CH_W-1:0] rgb_o,
  input logic                 sw_o
);

  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_video : assert (rgb_o == '0 && sw_o == 1'b0)
        else $error("R1 reset state wrong");
    end
  end

  if (PIPE_DEPTH == 2) begin : g_d2
    a_r2_rgb_latency : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q == 2'd3 |-> rgb_o == $past(rgb_i, 2));

    a_r3_coincident : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 2'd3 && $past(align_sel_i) == 3'b000)
      |-> sw_o == ($past(sw_i, 2) ^ $past(sw_pol_i)));

    a_r4_early : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 2'd3 && $past(align_sel_i) == 3'b001)
      |-> sw_o == ($past(sw_i) ^ $past(sw_pol_i)));

    a_r5_late : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 2'd3 && $past(align_sel_i) == 3'b010)
      |-> sw_o == ($past(sw_i, 3) ^ $past(sw_pol_i)));

    a_r6_undef_coinc : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 2'd3 && $past(align_sel_i) >= 3'b011)
      |-> sw_o == ($past(sw_i, 2) ^ $past(sw_pol_i)));

    // R8: a polarity flip alone, with constant switch history, flips the pin
    a_r8_pol_next_clk : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 2'd3 && $past(align_sel_i) == 3'b000 && $past(sw_pol_i) != $past(sw_pol_i, 2)
       && $past(align_sel_i, 2) == 3'b000 && $past(sw_i, 2) == $past(sw_i, 3))
      |-> sw_o != $past(sw_o));
  end

endmodule

bind vds_align_stage vds_align_chk #(
  .N_CH      (N_CH),
  .CH_W      (CH_W),
  .PIPE_DEPTH(PIPE_DEPTH)
) u_chk (.*);

// File: tb/vds_align_stage_tb_top.sv
`timescale 1ns/1ps
module vds_align_stage_tb_top;

  localparam int unsigned N_CH = 3;
  localparam int unsigned CH_W = 4;
  localparam int unsigned PW   = N_CH * CH_W;
  localparam int unsigned NROW = 12;

  // row: [6:4] align code, [3] polarity, [1:0] history index of expected switch
  localparam logic [6:0] VEC [NROW] = '{
    {3'b000, 1'b0, 1'b0, 2'd1},
    {3'b001, 1'b0, 1'b0, 2'd0},
    {3'b010, 1'b0, 1'b0, 2'd2},
    {3'b011, 1'b0, 1'b0, 2'd1},
    {3'b100, 1'b0, 1'b0, 2'd1},
    {3'b101, 1'b0, 1'b0, 2'd1},
    {3'b110, 1'b0, 1'b0, 2'd1},
    {3'b111, 1'b0, 1'b0, 2'd1},
    {3'b000, 1'b1, 1'b0, 2'd1},
    {3'b001, 1'b1, 1'b0, 2'd0},
    {3'b010, 1'b1, 1'b0, 2'd2},
    {3'b101, 1'b1, 1'b0, 2'd1}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    align_sel_i = 3'b000;
  logic          sw_pol_i = 1'b0;
  logic [PW-1:0] rgb_i = '0;
  logic          sw_i = 1'b0;
  logic [PW-1:0] rgb_o;
  logic          sw_o;

  int            n_chk = 0;
  int            n_bad = 0;
  logic [15:0]   lfsr = 16'hACE1;
  logic          h_sw [3];
  logic [PW-1:0] h_rgb [3];

  always #4 clk_i = ~clk_i;

  vds_align_stage #(.N_CH(N_CH), .CH_W(CH_W)) dut_i (
    .clk_i, .rst_ni, .align_sel_i, .sw_pol_i, .rgb_i, .sw_i, .rgb_o, .sw_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_idx(input logic [2:0] code);
    if (code == 3'b001) return 0;
    if (code == 3'b010) return 2;
    return 1;
  endfunction

  function automatic string mode_tag(input logic [2:0] code);
    if (code == 3'b000) return "R3";
    if (code == 3'b001) return "R4";
    if (code == 3'b010) return "R5";
    return "R6";
  endfunction

  task automatic clear_hist();
    for (int i = 0; i < 3; i++) begin
      h_sw[i]  = 1'b0;
      h_rgb[i] = '0;
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // called at a negedge; drives, waits one edge, checks at the next negedge
  task automatic tick(input logic s, input logic [PW-1:0] c, input logic [2:0] m,
                      input logic p, input string tag);
    string t;
    sw_i = s; rgb_i = c; align_sel_i = m; sw_pol_i = p;
    h_sw[2] = h_sw[1];   h_sw[1] = h_sw[0];   h_sw[0] = s;
    h_rgb[2] = h_rgb[1]; h_rgb[1] = h_rgb[0]; h_rgb[0] = c;
    @(posedge clk_i);
    @(negedge clk_i);
    t = (tag != "") ? tag : (p ? {mode_tag(m), "/R7"} : mode_tag(m));
    chk(t, 32'(sw_o), 32'(h_sw[exp_idx(m)] ^ p));
    chk("R2", 32'(rgb_o), 32'(h_rgb[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk_i);
    chk("R1", 32'(rgb_o), 32'h0);
    chk("R1", 32'(sw_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", 32'(sw_o), 32'h0);

    // table walk: all codes, both polarities
    for (int r = 0; r < NROW; r++) begin
      for (int k = 0; k < 24; k++) begin
        step_lfsr();
        tick(lfsr[0], lfsr[PW:1], VEC[r][6:4], VEC[r][3], "");
        if (exp_idx(VEC[r][6:4]) != int'(VEC[r][1:0])) begin
          chk("R6 table", 32'(exp_idx(VEC[r][6:4])), 32'(VEC[r][1:0]));
        end
      end
    end

    // R8: polarity toggled every clock with constant switch
    for (int k = 0; k < 3; k++) tick(1'b1, 12'h5A5, 3'b000, 1'b0, "R8");
    for (int k = 0; k < 8; k++) tick(1'b1, 12'h5A5, 3'b000, k[0] ? 1'b0 : 1'b1, "R8");

    // R8: early/late swapped every clock, delay line keeps its history
    for (int k = 0; k < 16; k++) begin
      step_lfsr();
      tick(lfsr[3], lfsr[11:0], k[0] ? 3'b010 : 3'b001, 1'b0, "R8");
    end

    // R3 single pulse through coincident path
    for (int k = 0; k < 3; k++) tick(1'b0, 12'h000, 3'b000, 1'b0, "R3");
    tick(1'b1, 12'hFFF, 3'b000, 1'b0, "R3");
    for (int k = 0; k < 3; k++) tick(1'b0, 12'h000, 3'b000, 1'b0, "R3");

    // R1: asynchronous reset mid-stream
    sw_i = 1'b1; rgb_i = 12'hFFF; sw_pol_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", 32'(rgb_o), 32'h0);
    chk("R1", 32'(sw_o), 32'h0);
    @(negedge clk_i);
    chk("R1", 32'(sw_o), 32'h0);
    clear_hist();
    rst_ni = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step_lfsr();
      tick(lfsr[1], lfsr[12:1], 3'b010, 1'b0, "R1/R5");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule